// File: doc/BRIEF.md
# Serial-Output Converter Conversion Sequencer

This block is the digital control of a 12-bit sampling converter with a three-wire serial output. A host pulls chip select low to freeze the input sample and start a conversion. An on-chip clock times the conversion by counting cycles. When the count runs out, the block takes the result word from an abstracted successive-approximation core into an output shift register. The host then clocks the word out on the falling edges of the serial clock.

The single data line carries two things. It is driven low while the conversion runs. It rises when the result is ready, and that high level is the framing bit ahead of the twelve data bits. The data bits come out MSB first, and zeros follow once the last bit has gone.

Chip select, serial clock and the active-low shutdown request arrive asynchronously. Each passes through a register synchronizer in the on-chip clock domain before edge detection. If chip select rises before the conversion completes, the conversion is aborted and an acquisition recovery interval begins. Holding the shutdown request low stops all activity. After release, a wake-up interval must pass before a new conversion can start.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is high and just after it falls, dout_oe, hold and conv_start are 0 and status is idle (code 0).
- R2: A chip-select falling edge in idle starts a conversion SYNC_STAGES+1 clock cycles later. From that cycle, hold=1, dout_oe=1, dout=0 and status=converting (code 1), and conv_start is high for exactly one cycle.
- R3: The conversion lasts CONV_CYCLES clock cycles. On the last of these cycles dout is still 0. On the next cycle dout=1 and status=data ready (code 2).
- R4: The result is captured from sar_result on the cycle the conversion ends. Later changes on sar_result do not alter the bits shifted out.
- R5: In data ready, the n-th serial-clock falling edge (n = 1..12) puts result bit 12-n on dout, so bit 11 comes first.
- R6: Serial-clock falling edges after the twelfth, with chip select still low, put 0 on dout.
- R7: Serial-clock falling edges during a conversion are ignored: dout stays 0, and the word read afterwards starts with the framing 1 followed by bit 11.
- R8: Once chip select has been high for SYNC_STAGES+1 cycles, dout_oe=0 and hold=0. A completed read then returns to idle.
- R9: If chip select rises during a conversion, the conversion is aborted. For ACQ_CYCLES cycles afterwards, chip-select falling edges start nothing (dout_oe stays 0, status idle). After that interval a falling edge starts a conversion again.
- R10: Once shdn_n has been low for SYNC_STAGES+1 cycles, status=shutdown (code 3) and dout_oe=0, even mid-conversion. Chip-select falling edges are then ignored.
- R11: After shdn_n rises, status stays shutdown and chip-select edges are ignored for WAKE_CYCLES cycles, counted from SYNC_STAGES+1 cycles after the rise. The block then moves straight to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running on-chip clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial read clock, asynchronous |
| shdn_n | input | 1 | Active-low shutdown request, asynchronous |
| sar_result | input | DATA_W | Result word from the conversion core |
| dout_oe | output | 1 | Drive enable for the serial data line |
| dout | output | 1 | Serial data value (busy low, framing 1, data, zeros) |
| hold | output | 1 | 1 = track/hold in hold, 0 = track |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| status | output | 2 | 0 idle, 1 converting, 2 data ready, 3 shutdown |

## Verification
Most faults in the state or counter show up on the data line. A wrong state shows as dout rising early or late relative to the exact cycle count from the chip-select edge, or as the line staying driven after chip select is released. A corrupted shift register shows at the first serial-clock falling edge as a missing framing bit or a misordered bit. A recovery or wake-up counter that is off by one shows as a start that is accepted or refused at the interval boundary, within SYNC_STAGES+1 cycles of the edge. Random result words, with random stray serial-clock pulses during conversion and random trailing clock counts, exercise the data path bit by bit.

// File: rtl/sar_serial_seq_pkg.sv
package sar_serial_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_CONVERT = 3'd1,
        SQ_READY   = 3'd2,
        SQ_RECOVER = 3'd3,
        SQ_SHDN    = 3'd4,
        SQ_WAKE    = 3'd5
    } seq_state_e;

    localparam logic [1:0] STS_IDLE  = 2'd0;
    localparam logic [1:0] STS_CONV  = 2'd1;
    localparam logic [1:0] STS_READY = 2'd2;
    localparam logic [1:0] STS_SHDN  = 2'd3;

    // Map internal states onto the externally visible status code.
    function automatic logic [1:0] status_of(seq_state_e s);
        case (s)
            SQ_CONVERT:      return STS_CONV;
            SQ_READY:        return STS_READY;
            SQ_SHDN, SQ_WAKE: return STS_SHDN;
            default:         return STS_IDLE;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic line_driven(seq_state_e s);
        return (s == SQ_CONVERT) || (s == SQ_READY);
    endfunction

endpackage

// File: rtl/sar_serial_seq_sync.sv
module sar_serial_seq_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_serial_seq_timer.sv
module sar_serial_seq_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sar_serial_seq_shifter.sv
module sar_serial_seq_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_in,
    output logic              msb
);
    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr <= '0;
        end else if (load) begin
            sr <= {1'b1, data_in};
        end else if (shift) begin
            sr <= {sr[SR_W-2:0], 1'b0};
        end
    end

    assign msb = sr[SR_W-1];
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_serial_seq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CYCLES = 40,
    parameter int ACQ_CYCLES  = 8,
    parameter int WAKE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              shdn_n,
    input  logic [DATA_W-1:0] sar_result,
    output logic              dout_oe,
    output logic              dout,
    output logic              hold,
    output logic              conv_start,
    output logic [1:0]        status
);
    localparam int CNT_MAX = max3(CONV_CYCLES, ACQ_CYCLES, WAKE_CYCLES);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] ACQ_LD  = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYCLES - 1);

    // Synchronized pins: bit 0 chip select, bit 1 serial clock, bit 2 shutdown
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, shdn_s;
    logic       cs_prev, sclk_prev;
    logic       cs_fall, sclk_fall;

    sar_serial_seq_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b101)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({shdn_n, sclk, cs_n}),
        .q   (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign sclk_s = pins_s[1];
    assign shdn_s = pins_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   = cs_prev & ~cs_s;
    assign sclk_fall = sclk_prev & ~sclk_s;

    // Sequencer
    seq_state_e       st, st_n;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sr_clear, sr_load, sr_shift;
    logic             start_n, start_q;

    always_comb begin
        st_n     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sr_clear = 1'b0;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        start_n  = 1'b0;
        if (!shdn_s) begin
            st_n = SQ_SHDN;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (cs_fall) begin
                        st_n     = SQ_CONVERT;
                        tmr_load = 1'b1;
                        tmr_val  = CONV_LD;
                        sr_clear = 1'b1;
                        start_n  = 1'b1;
                    end
                end
                SQ_CONVERT: begin
                    if (cs_s) begin
                        st_n     = SQ_RECOVER;
                        tmr_load = 1'b1;
                        tmr_val  = ACQ_LD;
                    end else if (tmr_expired) begin
                        st_n    = SQ_READY;
                        sr_load = 1'b1;
                    end
                end
                SQ_READY: begin
                    if (cs_s) begin
                        st_n = SQ_IDLE;
                    end else if (sclk_fall) begin
                        sr_shift = 1'b1;
                    end
                end
                SQ_RECOVER: begin
                    if (tmr_expired) begin
                        st_n = SQ_IDLE;
                    end
                end
                SQ_SHDN: begin
                    st_n     = SQ_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LD;
                end
                SQ_WAKE: begin
                    if (tmr_expired) begin
                        st_n = SQ_IDLE;
                    end
                end
                default: st_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            start_q <= 1'b0;
        end else begin
            st      <= st_n;
            start_q <= start_n;
        end
    end

    sar_serial_seq_timer #(
        .W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sar_serial_seq_shifter #(
        .DATA_W (DATA_W)
    ) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (sr_clear),
        .load    (sr_load),
        .shift   (sr_shift),
        .data_in (sar_result),
        .msb     (dout)
    );

    assign dout_oe    = line_driven(st);
    assign hold       = line_driven(st);
    assign conv_start = start_q;
    assign status     = status_of(st);
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk
    import sar_serial_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       shdn_n,
    input logic       dout_oe,
    input logic       dout,
    input logic       hold,
    input logic       conv_start,
    input logic [1:0] status
);
    AST_START_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (status == STS_CONV) && hold); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R2

    AST_BUSY_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (status == STS_CONV) |-> (dout_oe && !dout)); // R2

    AST_EOC_FRAME_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((status == STS_READY) && ($past(status) == STS_CONV)) |-> dout); // R3

    AST_RELEASED_HIGHZ: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!dout_oe && !hold)); // R8

    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n && !$past(shdn_n) && !$past(shdn_n, 2) && !$past(shdn_n, 3))
        |-> ((status == STS_SHDN) && !dout_oe)); // R10

    AST_WAKE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (($past(status) == STS_SHDN) && (status != STS_SHDN)) |-> (status == STS_IDLE)); // R11
endmodule

bind sar_serial_seq sar_serial_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .shdn_n     (shdn_n),
    .dout_oe    (dout_oe),
    .dout       (dout),
    .hold       (hold),
    .conv_start (conv_start),
    .status     (status)
);

// File: tb/sar_serial_seq_tb_top.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;
    localparam int DW   = 12;
    localparam int CONV = 40;
    localparam int ACQ  = 8;
    localparam int WAKE = 16;
    localparam int LAT  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          shdn_n = 1'b1;
    logic [DW-1:0] sar = '0;
    logic          dout_oe, dout, hold, conv_start;
    logic [1:0]    status;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sar_serial_seq #(
        .DATA_W      (DW),
        .SYNC_STAGES (2),
        .CONV_CYCLES (CONV),
        .ACQ_CYCLES  (ACQ),
        .WAKE_CYCLES (WAKE)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .shdn_n     (shdn_n),
        .sar_result (sar),
        .dout_oe    (dout_oe),
        .dout       (dout),
        .hold       (hold),
        .conv_start (conv_start),
        .status     (status)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected line value after idx serial falls: frame bit, data MSB first, then zeros
    function automatic logic exp_bit(logic [DW-1:0] d, int idx);
        if (idx == 0) return 1'b1;
        if (idx <= DW) return d[DW-idx];
        return 1'b0;
    endfunction

    task automatic sclk_pulse();
        sclk = 1'b1;
        tick(2);
        sclk = 1'b0;
        tick(LAT);
    endtask

    task automatic run_conv(logic [DW-1:0] data, int toggles, int extra);
        int elapsed;
        sar  = data;
        cs_n = 1'b0;
        tick(LAT);
        chk("R2 status converting", status, 1);
        chk("R2 line driven", dout_oe, 1);
        chk("R2 hold", hold, 1);
        chk("R2 busy low", dout, 0);
        chk("R2 start pulse", conv_start, 1);
        tick(1);
        chk("R2 start single cycle", conv_start, 0);
        elapsed = LAT + 1;
        for (int t = 0; t < toggles; t++) begin
            sclk_pulse();
            elapsed += 5;
            chk("R7 sclk ignored while busy", dout, 0);
        end
        tick(LAT - 1 + CONV - elapsed);
        chk("R3 still busy at last cycle", dout, 0);
        chk("R3 status at last cycle", status, 1);
        tick(1);
        chk("R3 eoc frame high", dout, 1);
        chk("R3 status ready", status, 2);
        sar = ~data;
        for (int i = 1; i <= DW + extra; i++) begin
            sclk_pulse();
            if (i <= DW)
                chk("R5 data bit (R4 latched word, R7)", dout, exp_bit(data, i));
            else
                chk("R6 trailing zero", dout, 0);
        end
        cs_n = 1'b1;
        tick(LAT);
        chk("R8 line released", dout_oe, 0);
        chk("R8 track mode", hold, 0);
        chk("R8 back to idle", status, 0);
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2E3F4));
        tick(5);
        chk("R1 oe in reset", dout_oe, 0);
        chk("R1 start in reset", conv_start, 0);
        rst = 1'b0;
        tick(2);
        chk("R1 status after reset", status, 0);
        chk("R1 hold after reset", hold, 0);
        chk("R1 oe after reset", dout_oe, 0);

        // Directed words
        run_conv(12'hFFF, 0, 0);
        run_conv(12'h000, 2, 3);
        run_conv(12'h800, 5, 1);
        run_conv(12'h001, 1, 4);

        // Random words with stray clocks and trailing clocks
        for (int n = 0; n < 16; n++) begin
            run_conv(DW'($urandom), $urandom_range(0, 5), $urandom_range(0, 4));
        end

        // Abort and acquisition recovery
        sar  = 12'hA5C;
        cs_n = 1'b0;
        tick(LAT + 10);
        chk("R9 converting before abort", status, 1);
        cs_n = 1'b1;
        tick(LAT);
        chk("R9 abort releases line", dout_oe, 0);
        chk("R9 abort status idle", status, 0);
        cs_n = 1'b0;
        tick(LAT + 1);
        chk("R9 start ignored in recovery", dout_oe, 0);
        chk("R9 no start pulse in recovery", conv_start, 0);
        cs_n = 1'b1;
        tick(ACQ + LAT + 2);
        cs_n = 1'b0;
        tick(LAT);
        chk("R9 start after recovery", status, 1);
        cs_n = 1'b1;
        tick(LAT + ACQ + 4);

        // Shutdown from idle, ignored start, wake-up interval
        shdn_n = 1'b0;
        tick(LAT);
        chk("R10 shutdown status", status, 3);
        cs_n = 1'b0;
        tick(LAT + 1);
        chk("R10 start ignored in shutdown", dout_oe, 0);
        chk("R10 track in shutdown", hold, 0);
        cs_n = 1'b1;
        tick(LAT);
        shdn_n = 1'b1;
        tick(LAT);
        cs_n = 1'b0;
        tick(4);
        chk("R11 start ignored while waking", dout_oe, 0);
        chk("R11 status during wake", status, 3);
        cs_n = 1'b1;
        tick(2 + WAKE - 7);
        chk("R11 last wake cycle", status, 3);
        tick(1);
        chk("R11 idle after wake", status, 0);
        tick(2);
        run_conv(12'h3C7, 1, 0);

        // Shutdown in the middle of a conversion
        cs_n = 1'b0;
        tick(LAT + 8);
        shdn_n = 1'b0;
        tick(LAT);
        chk("R10 shutdown aborts conversion", status, 3);
        chk("R10 line released in shutdown", dout_oe, 0);
        shdn_n = 1'b1;
        cs_n   = 1'b1;
        tick(WAKE + LAT + 4);
        chk("R11 idle after mid-conversion shutdown", status, 0);
        run_conv(12'h5A3, 0, 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule